// File: doc/BRIEF.md
# Dual-Limit Alternating Interval Timer

This block is a 16-bit up-counting interval timer with two terminal-count registers, called primary and secondary. In single mode only the primary limit is used, and the output pin drops low for one clock at every wrap. In dual mode the timer swaps limits at each wrap, so the output is high for one programmed interval and low for the other. The high time and the low time are therefore set independently.

The counter advances at most once every fourth system clock. Each advance comes from the internal enable or from a rising edge on an external clock input. That input is synchronized and aligned to the quarter-rate sample slot. Software programs the timer through a small write port: a 2-bit address, 16 bits of data and a write strobe. The count, both limits and the control word are always visible on output ports. Control word bit positions are: 0 run enable, 1 dual mode, 2 continuous, 3 external source, 4 active-limit status (read-only), 5 terminal-count flag.

Top module: `alt_interval_timer`

## Requirements
- R1: When an advance takes the count to the active limit, the count becomes 0 on that same edge. The count never holds the active limit after an advance.
- R2: A limit value of 0 acts as a limit of 65536, so the count runs from 0xFFFF to 0.
- R3: In single mode (control bit 1 clear), the output is low for exactly one clock after each terminal count and high at all other times.
- R4: In dual mode (control bit 1 set), the timer starts on the primary limit and switches between primary and secondary at every terminal count. Clearing dual mode returns it to primary.
- R5: In dual mode, the output is high while the primary limit is active and low while the secondary limit is active. Control bit 4 reads 1 while the secondary limit is active.
- R6: The count advances at most once per four clocks. With the internal source and run enable set (control bit 0), it advances exactly once per four clocks. With run enable clear, the count does not change.
- R7: With the external source selected (control bit 3), the count advances once per rising edge of the external input. The new count is visible within six clocks of that edge. A static external input causes no advance.
- R8: With continuous (control bit 2) clear, run enable is cleared at the first terminal count, and counting stops.
- R9: Control bit 5 is set at every terminal count. A control write with bit 5 at 0 clears it, and a control write with bit 5 at 1 leaves it unchanged.
- R10: Writes decode address 0 to control, 1 to count, 2 to primary limit and 3 to secondary limit. Each output port mirrors its register. After reset all registers are 0 and the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count, 2 primary, 3 secondary |
| wr_data | input | 16 | Write data |
| ext_clk_in | input | 1 | External count source, asynchronous |
| tmr_out | output | 1 | Timer output pin |
| count_q | output | 16 | Current count |
| limit_a_q | output | 16 | Primary limit register |
| limit_b_q | output | 16 | Secondary limit register |
| ctrl_q | output | 16 | Control word including status and flag |

## Verification
The assertions check on every cycle that the advance spacing is at least four clocks and that the count never holds the active limit after an advance. They also check that a wrap clears the count and sets the flag, that the 65536 wrap happens, that a single-mode low pulse lasts one clock, that the output toggles at every dual-mode wrap, and that non-continuous runs stop. Only the bench scenarios can show the exact advance totals over long windows, the alternation pattern across several limit pairs, the external-edge latency bound, and the flag write semantics seen at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW = 16;

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_LIMA = 2'd2;
  localparam logic [1:0] A_LIMB = 2'd3;

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_DUAL = 1;
  localparam int B_CONT = 2;
  localparam int B_EXT  = 3;
  localparam int B_ACT  = 4;
  localparam int B_FLAG = 5;

  // a stored limit of zero means the full 2^CW range
  function automatic logic [CW:0] span_of(input logic [CW-1:0] lim);
    span_of = (lim == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, lim};
  endfunction

  // true when one more step reaches the limit
  function automatic logic at_limit(input logic [CW-1:0] cnt, input logic [CW-1:0] lim);
    at_limit = ({1'b0, cnt} + 1'b1) == span_of(lim);
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int SLOT_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ext_sel,
  input  logic ext_in,
  output logic adv
);
  localparam int PW = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLOT_DIV - 1);

  logic [PW-1:0]          phase_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   slot;
  logic                   rise;

  assign slot = (phase_q == LAST);
  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (slot) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // hold an edge seen between slots until the next slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (!ext_sel || slot) pend_q <= 1'b0;
    else if (rise) pend_q <= 1'b1;
  end

  assign adv = run_en & slot & (ext_sel ? (rise | pend_q) : 1'b1);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          dual,
  input  logic [CW-1:0] lim_a,
  input  logic [CW-1:0] lim_b,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] count,
  output logic          sec_act,
  output logic [CW-1:0] act_lim,
  output logic          term
);
  assign act_lim = (dual && sec_act) ? lim_b : lim_a;
  assign term    = adv & at_limit(count, act_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cnt_wr) count <= cnt_wdata;
    else if (term) count <= '0;
    else if (adv) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_act <= 1'b0;
    else if (!dual) sec_act <= 1'b0;
    else if (term) sec_act <= ~sec_act;
  end
endmodule

// File: rtl/tmr_out_drive.sv
module tmr_out_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic sec_act,
  input  logic term,
  output logic pin
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else pulse_q <= term & ~dual;
  end

  assign pin = dual ? ~sec_act : ~pulse_q;
endmodule

// File: rtl/alt_interval_timer.sv
module alt_interval_timer
  import tmr_pkg::*;
#(
  parameter int SLOT_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          ext_clk_in,
  output logic          tmr_out,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] limit_a_q,
  output logic [CW-1:0] limit_b_q,
  output logic [CW-1:0] ctrl_q
);
  logic          run_en, dual_en, cont_en, ext_en, flag_q;
  logic          adv_tick, term_evt, sec_act;
  logic [CW-1:0] act_lim;
  logic          wr_ctrl, wr_cnt, wr_lima, wr_limb;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == A_CNT);
  assign wr_lima = wr_en && (wr_addr == A_LIMA);
  assign wr_limb = wr_en && (wr_addr == A_LIMB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_a_q <= '0;
      limit_b_q <= '0;
    end else begin
      if (wr_lima) limit_a_q <= wr_data;
      if (wr_limb) limit_b_q <= wr_data;
    end
  end

  // control fields; a terminal count overrides a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      dual_en <= 1'b0;
      cont_en <= 1'b0;
      ext_en  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_en  <= wr_data[B_RUN];
        dual_en <= wr_data[B_DUAL];
        cont_en <= wr_data[B_CONT];
        ext_en  <= wr_data[B_EXT];
        if (!wr_data[B_FLAG]) flag_q <= 1'b0;
      end
      if (term_evt) begin
        flag_q <= 1'b1;
        if (!cont_en) run_en <= 1'b0;
      end
    end
  end

  tmr_tick_gen #(
    .SLOT_DIV   (SLOT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .ext_sel(ext_en),
    .ext_in (ext_clk_in),
    .adv    (adv_tick)
  );

  tmr_count_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_tick),
    .dual     (dual_en),
    .lim_a    (limit_a_q),
    .lim_b    (limit_b_q),
    .cnt_wr   (wr_cnt),
    .cnt_wdata(wr_data),
    .count    (count_q),
    .sec_act  (sec_act),
    .act_lim  (act_lim),
    .term     (term_evt)
  );

  tmr_out_drive u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .dual   (dual_en),
    .sec_act(sec_act),
    .term   (term_evt),
    .pin    (tmr_out)
  );

  always_comb begin
    ctrl_q         = '0;
    ctrl_q[B_RUN]  = run_en;
    ctrl_q[B_DUAL] = dual_en;
    ctrl_q[B_CONT] = cont_en;
    ctrl_q[B_EXT]  = ext_en;
    ctrl_q[B_ACT]  = sec_act;
    ctrl_q[B_FLAG] = flag_q;
  end
endmodule

// File: rtl/alt_interval_timer_chk.sv
module alt_interval_timer_chk
  import tmr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          adv_tick,
  input logic          term_evt,
  input logic [CW-1:0] act_lim,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] ctrl_q,
  input logic          tmr_out
);
  logic [1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 2'd3;
    else if (adv_tick) gap_q <= 2'd0;
    else if (gap_q != 2'd3) gap_q <= gap_q + 1'b1;
  end

  a_r6_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    adv_tick |-> (gap_q == 2'd3));

  a_r1_never_holds_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_tick && !wr_en && act_lim != '0) |=> (count_q != $past(act_lim)));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !wr_en) |=> (count_q == '0));

  a_r2_full_range: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_tick && !wr_en && act_lim == '0 && count_q == '1) |=> (count_q == '0));

  a_r3_one_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_DUAL] && !tmr_out && !wr_en) |=> tmr_out);

  a_r5_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_DUAL] && term_evt && !wr_en) |=> (tmr_out != $past(tmr_out)));

  a_r8_stop_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !ctrl_q[B_CONT]) |=> !ctrl_q[B_RUN]);

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> ctrl_q[B_FLAG]);
endmodule

bind alt_interval_timer alt_interval_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .adv_tick(adv_tick),
  .term_evt(term_evt),
  .act_lim (act_lim),
  .count_q (count_q),
  .ctrl_q  (ctrl_q),
  .tmr_out (tmr_out)
);

// File: tb/alt_interval_timer_tb.sv
module alt_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ext_clk_in = 1'b0;
  logic        tmr_out;
  logic [15:0] count_q, limit_a_q, limit_b_q, ctrl_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alt_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk_in(ext_clk_in), .tmr_out(tmr_out),
    .count_q(count_q), .limit_a_q(limit_a_q), .limit_b_q(limit_b_q),
    .ctrl_q(ctrl_q)
  );

  typedef struct packed {
    logic [15:0] la;
    logic [15:0] lb;
    logic        dual;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_sec;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd5, 16'd0, 1'b0, 8'd3, 16'd3, 1'b0},
    '{16'd5, 16'd0, 1'b0, 8'd7, 16'd2, 1'b0},
    '{16'd3, 16'd2, 1'b1, 8'd4, 16'd1, 1'b1},
    '{16'd3, 16'd2, 1'b1, 8'd5, 16'd0, 1'b0},
    '{16'd1, 16'd0, 1'b0, 8'd6, 16'd0, 1'b0},
    '{16'd4, 16'd4, 1'b1, 8'd9, 16'd1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int lows, prev_lo, back2back, toggles, last_o;
    logic [15:0] base;
    bit moved;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset count", count_q, 0);
    check("R10 reset ctrl", ctrl_q, 0);
    check("R10 reset limits", {limit_a_q, limit_b_q}, 0);
    check("R10 reset out", tmr_out, 1);
    rst_n = 1'b1;
    run(2);

    // vector table: R1 R4 R5 R6 count and limit selection
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0000);
      wr(2'd2, VECS[i].la);
      wr(2'd3, VECS[i].lb);
      check("R10 primary readback", limit_a_q, VECS[i].la);
      check("R10 secondary readback", limit_b_q, VECS[i].lb);
      wr(2'd0, 16'h0005 | (16'(VECS[i].dual) << 1));
      run(4 * int'(VECS[i].ticks));
      check("R1/R4 vector count", count_q, VECS[i].exp_cnt);
      check("R5 vector active status", ctrl_q[4], VECS[i].exp_sec);
      if (VECS[i].dual) check("R5 vector out level", tmr_out, !VECS[i].exp_sec);
    end

    // R3: single mode pulses with primary limit 3 over 12 advances
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'd3);
    wr(2'd0, 16'h0005);
    lows = 0; prev_lo = 0; back2back = 0;
    for (int k = 0; k < 48; k++) begin
      run(1);
      if (!tmr_out) begin
        lows++;
        if (prev_lo) back2back++;
      end
      prev_lo = !tmr_out;
    end
    check("R3 low pulse count", lows, 4);
    check("R3 low lasts one clock", back2back, 0);

    // R5: dual mode output level and toggles, primary 2 / secondary 3
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'd2); wr(2'd3, 16'd3);
    wr(2'd0, 16'h0007);
    toggles = 0; last_o = tmr_out; lows = 0;
    for (int k = 0; k < 40; k++) begin
      run(1);
      if (tmr_out != last_o) toggles++;
      if (tmr_out == ctrl_q[4]) lows++;
      last_o = tmr_out;
    end
    check("R5 dual toggles", toggles, 4);
    check("R5 out mismatches status", lows, 0);
    // R4: clearing dual returns to primary
    wr(2'd0, 16'h0000);
    run(1);
    check("R4 primary after dual clear", ctrl_q[4], 0);

    // R2: zero limit wraps at 65536
    wr(2'd1, 16'hFFFE); wr(2'd2, 16'd0);
    wr(2'd0, 16'h0005);
    run(4);
    check("R2 reaches FFFF", count_q, 16'hFFFF);
    run(4);
    check("R2 wraps to 0", count_q, 0);
    check("R9 flag set on wrap", ctrl_q[5], 1);

    // R9: flag write semantics
    wr(2'd0, 16'h0020);
    check("R9 write 1 keeps flag", ctrl_q[5], 1);
    wr(2'd0, 16'h0000);
    check("R9 write 0 clears flag", ctrl_q[5], 0);
    wr(2'd0, 16'h0020);
    check("R9 write 1 does not set flag", ctrl_q[5], 0);

    // R6: disabled holds; enabled counts once per four clocks
    wr(2'd0, 16'h0000); wr(2'd1, 16'd7);
    run(20);
    check("R6 disabled holds count", count_q, 7);
    wr(2'd1, 16'd0); wr(2'd2, 16'd1000);
    wr(2'd0, 16'h0005);
    run(100);
    check("R6 quarter rate", count_q, 25);

    // R8: non-continuous stops after first wrap
    wr(2'd0, 16'h0000); wr(2'd1, 16'd0); wr(2'd2, 16'd2);
    wr(2'd0, 16'h0001);
    run(20);
    check("R8 run cleared", ctrl_q[0], 0);
    check("R8 count at zero", count_q, 0);
    run(12);
    check("R8 stays stopped", count_q, 0);

    // R7: external source
    wr(2'd0, 16'h0000); wr(2'd1, 16'd0); wr(2'd2, 16'd100);
    wr(2'd0, 16'h000D);
    run(40);
    check("R7 static input no advance", count_q, 0);
    for (int p = 0; p < 3; p++) begin
      ext_clk_in = 1'b1; run(10);
      ext_clk_in = 1'b0; run(10);
    end
    check("R7 three edges", count_q, 3);
    for (int t = 0; t < 4; t++) begin
      base = count_q;
      ext_clk_in = 1'b1;
      moved = 0;
      for (int k = 0; k < 6; k++) begin
        run(1);
        if (count_q != base) moved = 1;
      end
      check("R7 response within six clocks", moved, 1);
      check("R7 single step per edge", count_q, base + 16'd1);
      ext_clk_in = 1'b0; run(3 + t);
    end

    finish_up();
  end
endmodule